// File: doc/BRIEF.md
# Filtered Change Detection Unit

This block watches an 8-bit digital input port and reports level changes on it. Every input bit can be routed through its own glitch filter before edge detection. The filters share one programmable stability interval, counted in steps of `STEP_CYCLES` clocks (200 ns at a 100 MHz clock). Two per-bit masks choose which bits report rising transitions and which report falling transitions. Any enabled transition sets a sticky rising or falling status flag. Software clears these flags by writing ones to them. An interrupt request is formed from the flags, two per-kind enables and a master enable.

Two capture modes are provided. Asynchronous capture is the reset mode: the detector compares the port with its previous value on every clock, so a pulse that lasts a single clock is still recorded. Synchronous capture compares only on the step tick, which fires once every `STEP_CYCLES` clocks. Shorter activity between two ticks is then invisible. Software reaches the configuration and the status through a simple register port: a write strobe, a 3-bit address, 32-bit write data and combinational read data.

Top module: `chg_detect_unit`

## Requirements
- R1: After reset, every register reads zero, capture mode is asynchronous (mode bit 0 = 0) and `irq` is low.
- R2: A 0-to-1 change of a bit whose rise mask bit (address 0) is set sets the rising flag (status bit 0, address 4) on the second clock edge after the port is sampled. A rise on an unmasked bit leaves the flag clear.
- R3: A 1-to-0 change of a bit whose fall mask bit (address 1) is set sets the falling flag (status bit 1). A fall on an unmasked bit leaves the flag clear.
- R4: The status flags stay set until a write to address 4 with a 1 in the flag's bit position. Writing 0 there leaves the flag set. When a new event and a clear arrive in the same cycle, the flag stays set.
- R5: `irq` equals control bit 2 (master enable, address 5) ANDed with the OR of (bit 0 AND rising flag) and (bit 1 AND falling flag).
- R6: When a bit's filter enable (address 2) is set, the detector sees a new level on that bit only after the raw input has held it for the programmed number of step ticks. A shorter glitch causes no event.
- R7: The filter interval (address 3) holds 20 bits. Bits 31:20 read back as zero, whatever was written to them.
- R8: In asynchronous mode, a port pulse that lasts one clock sets both the rising and the falling flag when both masks enable the bit.
- R9: In synchronous mode (address 6 bit 0 = 1), edges are evaluated only on the step tick. The tick fires on clock edge n after reset release when n is a multiple of `STEP_CYCLES`. A pulse that lies entirely between two ticks is missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Monitored digital port |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hard case is a new edge that lands in the same cycle as a software write-one-to-clear of the flag it sets. The bench drives the port change one cycle before the clear write, so that the detector's set and the clear meet on the same clock edge. It then expects the flag to read back as 1. A second clear with the port quiet must bring the flag back to 0. Random port vectors and random masks and enables are checked against flag and interrupt values computed in the bench. Directed cases cover the filter window and the tick phase of synchronous mode.

// File: rtl/chg_pkg.sv
// Shared register addresses and types for the change detection unit.
// Assumes a 3-bit register address.
package chg_pkg;
    localparam logic [2:0] ADDR_RISE   = 3'd0;
    localparam logic [2:0] ADDR_FALL   = 3'd1;
    localparam logic [2:0] ADDR_FILT   = 3'd2;
    localparam logic [2:0] ADDR_IVAL   = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;
    localparam logic [2:0] ADDR_CTRL   = 3'd5;
    localparam logic [2:0] ADDR_MODE   = 3'd6;

    typedef enum logic {
        CAP_ASYNC = 1'b0,
        CAP_SYNC  = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic master;
        logic fall_ie;
        logic rise_ie;
    } irq_ctrl_t;
endpackage

// File: rtl/cdu_step_timer.sv
// Step timer: a free-running prescaler that pulses tick for one clock
// every STEP_CYCLES clocks, counted from reset release.
// Assumes STEP_CYCLES >= 2.
module cdu_step_timer #(
    parameter int STEP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Purpose: wrap the prescaler at the end of each step.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);

    // R9: ticks are never back to back.
    p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cdu_glitch_filter.sv
// Glitch filter for one bit. The output takes the raw level only after
// the raw level has differed from the output for ival step ticks.
// Assumes raw is already registered in the clock domain.
module cdu_glitch_filter #(
    parameter int IVAL_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [IVAL_W-1:0] ival,
    input  logic              raw,
    output logic              level
);
    logic [IVAL_W-1:0] cnt;

    // Purpose: count stable ticks and hand the new level over once enough have passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (raw == level) begin
            cnt <= '0;
        end else if (cnt >= ival) begin
            level <= raw;
            cnt   <= '0;
        end else if (tick) begin
            cnt <= cnt + IVAL_W'(1);
        end
    end

    // R6: the output only ever moves to the level the raw input held.
    p_filter_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (level == $past(raw)));
endmodule

// File: rtl/cdu_edge_latch.sv
// Edge latch: compares the selected port levels with the previous sample
// whenever sample_en is high, and sets the sticky rising and falling flags.
// Clears come from software; a set in the same cycle wins.
module cdu_edge_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] rise_mask,
    input  logic [WIDTH-1:0] fall_mask,
    input  logic             clr_rise,
    input  logic             clr_fall,
    output logic             rise_flag,
    output logic             fall_flag
);
    logic [WIDTH-1:0] det_q;
    logic             rise_hit;
    logic             fall_hit;

    assign rise_hit = sample_en && |(lvl & ~det_q & rise_mask);
    assign fall_hit = sample_en && |(~lvl & det_q & fall_mask);

    // Purpose: keep the last sampled level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)         det_q <= '0;
        else if (sample_en) det_q <= lvl;
    end

    // Purpose: sticky flags, where a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else begin
            rise_flag <= rise_hit | (rise_flag & ~clr_rise);
            fall_flag <= fall_hit | (fall_flag & ~clr_fall);
        end
    end

    // R4: a flag stays set without a clear.
    p_sticky_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_flag && !clr_rise) |=> rise_flag);
    p_sticky_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_flag && !clr_fall) |=> fall_flag);
    // R9: with no sample, the comparison state holds.
    p_hold_no_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(det_q));
endmodule

// File: rtl/chg_detect_unit.sv
// Filtered change detection unit (top). It holds the configuration
// registers, samples the port, applies the per-bit filters and the
// capture mode, and drives the interrupt request.
// Assumes pin_in is synchronous to clk, or tolerates one register of
// sampling.
module chg_detect_unit
    import chg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int IVAL_W      = 20,
    parameter int STEP_CYCLES = 20,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [WIDTH-1:0]  rise_mask;
    logic [WIDTH-1:0]  fall_mask;
    logic [WIDTH-1:0]  filt_en;
    logic [IVAL_W-1:0] ival;
    irq_ctrl_t         ctrl;
    cap_mode_e         cap_mode;
    logic [WIDTH-1:0]  in_q;
    logic [WIDTH-1:0]  filt_lvl;
    logic [WIDTH-1:0]  lvl;
    logic              tick;
    logic              sample_en;
    logic              clr_rise;
    logic              clr_fall;
    logic              rise_flag;
    logic              fall_flag;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:IVAL_W];

    // Purpose: configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_mask <= '0;
            fall_mask <= '0;
            filt_en   <= '0;
            ival      <= '0;
            ctrl      <= '0;
            cap_mode  <= CAP_ASYNC;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_RISE: rise_mask <= reg_wdata[WIDTH-1:0];
                ADDR_FALL: fall_mask <= reg_wdata[WIDTH-1:0];
                ADDR_FILT: filt_en   <= reg_wdata[WIDTH-1:0];
                ADDR_IVAL: ival      <= reg_wdata[IVAL_W-1:0];
                ADDR_CTRL: ctrl      <= irq_ctrl_t'(reg_wdata[2:0]);
                ADDR_MODE: cap_mode  <= cap_mode_e'(reg_wdata[0]);
                default:   ;
            endcase
        end
    end

    assign clr_rise = reg_we && (reg_addr == ADDR_STATUS) && reg_wdata[0];
    assign clr_fall = reg_we && (reg_addr == ADDR_STATUS) && reg_wdata[1];

    // Purpose: register the port once every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pin_in;
    end

    cdu_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_filt
        cdu_glitch_filter #(.IVAL_W(IVAL_W)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .ival  (ival),
            .raw   (in_q[i]),
            .level (filt_lvl[i])
        );
        assign lvl[i] = filt_en[i] ? filt_lvl[i] : in_q[i];
    end

    assign sample_en = (cap_mode == CAP_ASYNC) || tick;

    cdu_edge_latch #(.WIDTH(WIDTH)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .lvl       (lvl),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .clr_rise  (clr_rise),
        .clr_fall  (clr_fall),
        .rise_flag (rise_flag),
        .fall_flag (fall_flag)
    );

    assign irq = ctrl.master & ((ctrl.rise_ie & rise_flag) | (ctrl.fall_ie & fall_flag));

    // Purpose: read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_RISE:   reg_rdata = {{(DATA_W-WIDTH){1'b0}}, rise_mask};
            ADDR_FALL:   reg_rdata = {{(DATA_W-WIDTH){1'b0}}, fall_mask};
            ADDR_FILT:   reg_rdata = {{(DATA_W-WIDTH){1'b0}}, filt_en};
            ADDR_IVAL:   reg_rdata = {{(DATA_W-IVAL_W){1'b0}}, ival};
            ADDR_STATUS: reg_rdata = {{(DATA_W-2){1'b0}}, fall_flag, rise_flag};
            ADDR_CTRL:   reg_rdata = {{(DATA_W-3){1'b0}}, ctrl};
            ADDR_MODE:   reg_rdata = {{(DATA_W-1){1'b0}}, cap_mode};
            default:     reg_rdata = '0;
        endcase
    end

    // R5: an interrupt needs a set flag and the master enable.
    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.master && (rise_flag || fall_flag)));
    // R2: a rising flag never appears with all rise masks clear.
    p_rise_needs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rise_flag) && $past(rst_n)) |-> ($past(rise_mask) != '0));
endmodule

// File: tb/chg_detect_unit_test.sv
module chg_detect_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = 8'h00;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    int          ecount = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    chg_detect_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

    function automatic logic exp_rise(logic [7:0] p, logic [7:0] n, logic [7:0] m);
        return |(n & ~p & m);
    endfunction
    function automatic logic exp_fall(logic [7:0] p, logic [7:0] n, logic [7:0] m);
        return |(~n & p & m);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_pin(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", d, 32'h0);
        end
        chk("R1 irq reset", {31'h0, irq}, 32'h0);

        // R7: interval width
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d);
        chk("R7 interval readback", d, 32'h000F_FFFF);
        wr(3'd3, 32'h0);

        // R2: masked and unmasked rises
        wr(3'd0, 32'h01);
        set_pin(8'h02); repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R2 unmasked rise ignored", d, 32'h0);
        set_pin(8'h03); repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R2 masked rise sets flag", d, 32'h1);

        // R4: write 0 keeps, write 1 clears
        wr(3'd4, 32'h0); rd(3'd4, d); chk("R4 zero write keeps flag", d, 32'h1);
        wr(3'd4, 32'h1); rd(3'd4, d); chk("R4 w1c clears flag", d, 32'h0);

        // R3: falls
        wr(3'd1, 32'h02);
        set_pin(8'h02); repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R3 unmasked fall ignored", d, 32'h0);
        set_pin(8'h00); repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R3 masked fall sets flag", d, 32'h2);
        wr(3'd4, 32'h3);

        // R4: set wins over a clear in the same cycle
        @(negedge clk); pin_in = 8'h01;
        @(negedge clk); reg_addr = 3'd4; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        rd(3'd4, d); chk("R4 set beats clear", d, 32'h1);
        wr(3'd4, 32'h1); rd(3'd4, d); chk("R4 clear after collision", d, 32'h0);

        // R5: interrupt gating
        set_pin(8'h00); repeat (2) @(negedge clk);
        set_pin(8'h01); repeat (2) @(negedge clk);
        wr(3'd5, 32'h1); #1 chk("R5 no master", {31'h0, irq}, 32'h0);
        wr(3'd5, 32'h5); #1 chk("R5 rise enabled", {31'h0, irq}, 32'h1);
        wr(3'd5, 32'h6); #1 chk("R5 only fall enabled", {31'h0, irq}, 32'h0);
        wr(3'd4, 32'h3); wr(3'd5, 32'h0);

        // R8: single-clock pulse in async mode
        wr(3'd0, 32'h10); wr(3'd1, 32'h10);
        @(negedge clk); pin_in = 8'h11;
        @(negedge clk); pin_in = 8'h01;
        repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R8 one-clock pulse", d, 32'h3);
        wr(3'd4, 32'h3);

        // R9: synchronous mode phase
        wr(3'd6, 32'h1);
        do @(negedge clk); while (ecount % 20 != 5);
        pin_in = 8'h11;
        @(negedge clk); pin_in = 8'h01;
        repeat (25) @(negedge clk);
        rd(3'd4, d); chk("R9 pulse between ticks missed", d, 32'h0);
        do @(negedge clk); while (ecount % 20 != 5);
        pin_in = 8'h11;
        repeat (13) @(negedge clk);
        rd(3'd4, d); chk("R9 no flag before tick", d, 32'h0);
        repeat (2) @(negedge clk);
        rd(3'd4, d); chk("R9 flag at tick", d, 32'h1);
        wr(3'd6, 32'h0); set_pin(8'h01); repeat (3) @(negedge clk);
        wr(3'd4, 32'h3);

        // R6: filter with interval 3
        wr(3'd0, 32'h01); wr(3'd1, 32'h01); wr(3'd2, 32'h01); wr(3'd3, 32'h3);
        set_pin(8'h00); repeat (80) @(negedge clk);
        wr(3'd4, 32'h3);
        set_pin(8'h01); repeat (30) @(negedge clk);
        pin_in = 8'h00; repeat (10) @(negedge clk);
        rd(3'd4, d); chk("R6 glitch rejected", d, 32'h0);
        repeat (80) @(negedge clk);
        set_pin(8'h01);
        repeat (39) @(negedge clk);
        rd(3'd4, d); chk("R6 not before interval", d, 32'h0);
        repeat (25) @(negedge clk);
        rd(3'd4, d); chk("R6 passes after interval", d, 32'h1);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        set_pin(8'h00); repeat (3) @(negedge clk);
        wr(3'd4, 32'h3);

        // R2 R3 R5: random vectors
        prev = 8'h00;
        for (int i = 0; i < 150; i++) begin
            logic [7:0] rm, fm, nv;
            logic [2:0] ie;
            logic       er, ef;
            rm = 8'($urandom); fm = 8'($urandom); ie = 3'($urandom); nv = 8'($urandom);
            if (i % 10 == 0) nv = ~prev;
            wr(3'd0, {24'h0, rm}); wr(3'd1, {24'h0, fm}); wr(3'd5, {29'h0, ie});
            wr(3'd4, 32'h3);
            set_pin(nv); repeat (2) @(negedge clk);
            er = exp_rise(prev, nv, rm);
            ef = exp_fall(prev, nv, fm);
            rd(3'd4, d);
            chk("R2 R3 random flags", d, {30'h0, ef, er});
            chk("R5 random irq", {31'h0, irq}, {31'h0, ie[2] & ((ie[0] & er) | (ie[1] & ef))});
            prev = nv;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule